// File: doc/BRIEF.md
# Self-Checking Six-Operator Control Sequencer

This block is a small microprogrammed controller. It has five condition inputs and thirteen one-hot states. Six of the states are operator states, and each drives a fixed set of micro-operation lines for exactly one clock. The controller also has concurrent checking that looks for tampering. Each operator leaves certain condition inputs untouched. For four of the operators, the controller takes a snapshot of one such input as it enters the operator. In the check cycle that follows, it compares the live input with that snapshot.

A mismatch raises a sticky alarm. The alarm also covers a state register that is not exactly one-hot. Once the alarm is set, the controller parks in a halt state with every output quiet until reset. This catches sequences where every single output word is legal but the path through the chart is not. A host pulses `start` from idle and watches `done_o` to see the run complete.

Top module: `ctl_guarded_seq`

## Requirements
- R1: While reset is low, and after it is released, the controller is in idle with `uop_o` = 0, `done_o` = 0 and `alarm_o` = 0. Reset is asynchronous on assertion and is released through a two-flop synchronizer.
- R2: A `start` seen in idle selects the first operator from x1 = `cond_i[0]` and x2 = `cond_i[1]`:
  - x1 = 1 selects Y1.
  - x1 = 0 with x2 = 1 selects Y4.
  - x1 = 0 with x2 = 0 selects Y5.
  - `start` has no effect in any other state.
- R3: Each operator lasts one clock and drives `uop_o` (bit k is micro-operation y(k+1)) as follows: Y1 = 8'h03, Y2 = 8'h08, Y3 = 8'h4C, Y4 = 8'h60, Y5 = 8'h60, Y6 = 8'h80.
- R4: Y1, Y3, Y4 and Y5 are each followed by one check cycle with `uop_o` = 0. After a passing check:
  - After Y1 or Y4, the controller goes to Y3 if x4 = `cond_i[3]` is 1, otherwise to Y2.
  - After Y3 or Y5, it goes to Y6.
  - From Y2, it goes to Y6 if x3 = `cond_i[2]` is 1, otherwise to the end state.
  - From Y6, it goes to the end state if x5 = `cond_i[4]` is 1, otherwise to Y2.
- R5: Y3 is entered only on a clock edge where x4 = 1.
- R6: The check cycles test these inputs against the values they had when the operator was entered:
  - after Y1, x1 (which must still be 1);
  - after Y3, x4 (which must still be 1);
  - after Y4, x1 (which must still be 0);
  - after Y5, x2 (which must still be 0).
  A mismatch sets `alarm_o` on the next edge, and the controller halts.
- R7: Only the checked input matters. For example, a change of x3 during Y1 or of x2 during Y4 raises no alarm, and sequencing continues.
- R8: A state register holding zero bits set, or more than one bit set, sets `alarm_o` on the next edge, with `uop_o` = 0 meanwhile.
- R9: `alarm_o` stays set until reset. While it is set, `uop_o` = 0, `done_o` = 0 and `start` is ignored.
- R10: The end state raises `done_o` for exactly one clock and then returns to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run when idle |
| cond_i | input | 5 | Condition inputs x1..x5 in bits 0..4 |
| uop_o | output | 8 | Micro-operation lines y1..y8 in bits 0..7 |
| done_o | output | 1 | One-cycle end-of-run pulse |
| alarm_o | output | 1 | Sticky tamper alarm |

## Verification
The bench flips a checked input partway through each of the four guarded operators. A design that compared against the wrong input, or in the wrong cycle, would let the run finish instead of halting. It also flips inputs that the operators are not required to hold. A design that checked too much would raise false alarms on a legal run.

The bench forces a two-hot state vector to confirm that an illegal encoding is caught rather than decoded into mixed micro-operations. It then pulses `start` after the alarm, where a non-sticky alarm would wrongly restart the controller.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  localparam int unsigned NCOND = 5;
  localparam int unsigned NUOP  = 8;
  localparam int unsigned NST   = 13;

  // one-hot bit positions of the state vector
  localparam int S_IDLE = 0;
  localparam int S_Y1   = 1;
  localparam int S_Y2   = 2;
  localparam int S_Y3   = 3;
  localparam int S_Y4   = 4;
  localparam int S_Y5   = 5;
  localparam int S_Y6   = 6;
  localparam int S_C1   = 7;
  localparam int S_C3   = 8;
  localparam int S_C4   = 9;
  localparam int S_C5   = 10;
  localparam int S_END  = 11;
  localparam int S_HALT = 12;

  // condition input positions
  localparam int X1 = 0;
  localparam int X2 = 1;
  localparam int X3 = 2;
  localparam int X4 = 3;
  localparam int X5 = 4;

  // micro-operation words per operator
  localparam logic [NUOP-1:0] UOP_Y1 = 8'h03;
  localparam logic [NUOP-1:0] UOP_Y2 = 8'h08;
  localparam logic [NUOP-1:0] UOP_Y3 = 8'h4C;
  localparam logic [NUOP-1:0] UOP_Y4 = 8'h60;
  localparam logic [NUOP-1:0] UOP_Y5 = 8'h60;
  localparam logic [NUOP-1:0] UOP_Y6 = 8'h80;

  localparam logic [NST-1:0] ST_RESET = NST'(1) << S_IDLE;
endpackage

// File: rtl/ctl_rst_sync.sv
module ctl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/ctl_next.sv
module ctl_next
  import ctl_pkg::*;
(
  input  logic [NST-1:0]   state_q,
  input  logic [NCOND-1:0] cond,
  input  logic             start,
  input  logic             trip,
  output logic [NST-1:0]   state_d
);
  always_comb begin
    state_d = '0;
    if (trip) begin
      state_d[S_HALT] = 1'b1;
    end else if (state_q[S_IDLE]) begin
      if (!start)          state_d[S_IDLE] = 1'b1;
      else if (cond[X1])   state_d[S_Y1]   = 1'b1;
      else if (cond[X2])   state_d[S_Y4]   = 1'b1;
      else                 state_d[S_Y5]   = 1'b1;
    end else if (state_q[S_Y1]) begin
      state_d[S_C1] = 1'b1;
    end else if (state_q[S_Y3]) begin
      state_d[S_C3] = 1'b1;
    end else if (state_q[S_Y4]) begin
      state_d[S_C4] = 1'b1;
    end else if (state_q[S_Y5]) begin
      state_d[S_C5] = 1'b1;
    end else if (state_q[S_C1] || state_q[S_C4]) begin
      if (cond[X4]) state_d[S_Y3] = 1'b1;
      else          state_d[S_Y2] = 1'b1;
    end else if (state_q[S_C3] || state_q[S_C5]) begin
      state_d[S_Y6] = 1'b1;
    end else if (state_q[S_Y2]) begin
      if (cond[X3]) state_d[S_Y6]  = 1'b1;
      else          state_d[S_END] = 1'b1;
    end else if (state_q[S_Y6]) begin
      if (cond[X5]) state_d[S_END] = 1'b1;
      else          state_d[S_Y2]  = 1'b1;
    end else if (state_q[S_END]) begin
      state_d[S_IDLE] = 1'b1;
    end else begin
      state_d[S_HALT] = 1'b1;
    end
  end
endmodule

// File: rtl/ctl_guard.sv
module ctl_guard
  import ctl_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NST-1:0] state_q,
  input  logic [3:0]     entry_i,   // {Y5, Y4, Y3, Y1} being entered
  input  logic           x1,
  input  logic           x2,
  input  logic           x4,
  output logic           alarm_q,
  output logic           trip
);
  logic snap_q, snap_d, snap_en;
  logic in_chk, live, mismatch, illegal;

  // capture the watched input on entry to a guarded operator
  always_comb begin
    snap_en = |entry_i;
    if (entry_i[0] || entry_i[2]) snap_d = x1;
    else if (entry_i[1])          snap_d = x4;
    else                          snap_d = x2;
  end

  // compare in the cycle after the operator
  always_comb begin
    in_chk = state_q[S_C1] | state_q[S_C3] | state_q[S_C4] | state_q[S_C5];
    if (state_q[S_C1] || state_q[S_C4]) live = x1;
    else if (state_q[S_C3])             live = x4;
    else                                live = x2;
    mismatch = in_chk && (live != snap_q);
    illegal  = ($countones(state_q) != 1);
    trip     = alarm_q | mismatch | illegal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       snap_q <= 1'b0;
    else if (snap_en) snap_q <= snap_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alarm_q <= 1'b0;
    else        alarm_q <= trip;
  end
endmodule

// File: rtl/ctl_guarded_seq.sv
module ctl_guarded_seq
  import ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NCOND-1:0] cond_i,
  output logic [NUOP-1:0]  uop_o,
  output logic             done_o,
  output logic             alarm_o
);
  logic           rst_sync_n;
  logic [NST-1:0] state_q, state_d;
  logic           alarm_q, trip;
  logic [3:0]     entry;
  logic [NUOP-1:0] uop_raw;

  ctl_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  ctl_next u_next (
    .state_q(state_q), .cond(cond_i), .start(start),
    .trip(trip), .state_d(state_d)
  );

  assign entry = {state_d[S_Y5], state_d[S_Y4], state_d[S_Y3], state_d[S_Y1]};

  ctl_guard u_guard (
    .clk(clk), .rst_n(rst_sync_n), .state_q(state_q), .entry_i(entry),
    .x1(cond_i[X1]), .x2(cond_i[X2]), .x4(cond_i[X4]),
    .alarm_q(alarm_q), .trip(trip)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) state_q <= ST_RESET;
    else             state_q <= state_d;
  end

  always_comb begin
    uop_raw = '0;
    if (state_q[S_Y1]) uop_raw = uop_raw | UOP_Y1;
    if (state_q[S_Y2]) uop_raw = uop_raw | UOP_Y2;
    if (state_q[S_Y3]) uop_raw = uop_raw | UOP_Y3;
    if (state_q[S_Y4]) uop_raw = uop_raw | UOP_Y4;
    if (state_q[S_Y5]) uop_raw = uop_raw | UOP_Y5;
    if (state_q[S_Y6]) uop_raw = uop_raw | UOP_Y6;
  end

  // quiet whenever tripped or the encoding is illegal
  assign uop_o   = trip ? '0 : uop_raw;
  assign done_o  = state_q[S_END] && !trip;
  assign alarm_o = alarm_q;
endmodule

// File: rtl/ctl_guarded_seq_chk.sv
module ctl_guarded_seq_chk
  import ctl_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [NST-1:0]   state_q,
  input logic [NCOND-1:0] cond_i,
  input logic [NUOP-1:0]  uop_o,
  input logic             done_o,
  input logic             alarm_o
);
  // R9
  alarm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_o |=> alarm_o);

  // R9
  alarm_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_o |-> (uop_o == '0 && !done_o));

  // R5
  y3_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q[S_Y3] && !$past(state_q[S_Y3])) |-> $past(cond_i[X4]));

  // R6
  y1_check_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q[S_C1] && !cond_i[X1]) |=> alarm_o);

  // R8
  illegal_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(state_q) != 1) |=> alarm_o);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

bind ctl_guarded_seq ctl_guarded_seq_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .state_q(state_q), .cond_i(cond_i),
  .uop_o(uop_o), .done_o(done_o), .alarm_o(alarm_o)
);

// File: tb/tb_ctl_guarded_seq.sv
module tb_ctl_guarded_seq;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic [4:0] cond_i;
  logic [7:0] uop_o;
  logic       done_o, alarm_o;
  int n_vec = 0;
  int n_bad = 0;
  bit over = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctl_guarded_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cond_i(cond_i),
    .uop_o(uop_o), .done_o(done_o), .alarm_o(alarm_o)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic expect_out(input string req, input logic [7:0] eu,
                            input logic ed, input logic ea);
    n_vec++;
    if (uop_o !== eu || done_o !== ed || alarm_o !== ea) begin
      n_bad++;
      $display("FAIL %s: uop=%h done=%b alarm=%b expected uop=%h done=%b alarm=%b",
               req, uop_o, done_o, alarm_o, eu, ed, ea);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; start = 1'b0; cond_i = '0;
    tick();
    expect_out("R1 in reset", 8'h00, 1'b0, 1'b0);
    rst_n = 1'b1;
    repeat (3) tick();
    expect_out("R1 after release", 8'h00, 1'b0, 1'b0);
  endtask

  task automatic launch(input logic [4:0] c);
    cond_i = c; start = 1'b1;
    tick();
    start = 1'b0;
  endtask

  // x1=1, x4=0, x3=0 : Y1, check, Y2, end
  task automatic t_path_a();
    do_reset();
    launch(5'b00001);
    expect_out("R2 R3 Y1", 8'h03, 1'b0, 1'b0); tick();
    expect_out("R4 check after Y1", 8'h00, 1'b0, 1'b0); tick();
    expect_out("R4 Y2 via x4=0", 8'h08, 1'b0, 1'b0); tick();
    expect_out("R10 done", 8'h00, 1'b1, 1'b0); tick();
    expect_out("R10 back to idle", 8'h00, 1'b0, 1'b0);
    start = 1'b0; tick();
    expect_out("R2 no start stays idle", 8'h00, 1'b0, 1'b0);
  endtask

  // x2=1, x4=1, x5=1 : Y4, check, Y3, check, Y6, end
  task automatic t_path_b();
    do_reset();
    launch(5'b11010);
    expect_out("R2 R3 Y4", 8'h60, 1'b0, 1'b0); tick();
    expect_out("R4 check after Y4", 8'h00, 1'b0, 1'b0); tick();
    expect_out("R5 Y3 via x4=1", 8'h4C, 1'b0, 1'b0); tick();
    expect_out("R4 check after Y3", 8'h00, 1'b0, 1'b0); tick();
    expect_out("R3 Y6", 8'h80, 1'b0, 1'b0); tick();
    expect_out("R10 done via x5=1", 8'h00, 1'b1, 1'b0);
  endtask

  // x1=0, x2=0, x3=0, x5=0 : Y5, check, Y6, Y2, end
  task automatic t_path_c();
    do_reset();
    launch(5'b00000);
    expect_out("R2 R3 Y5", 8'h60, 1'b0, 1'b0); tick();
    expect_out("R4 check after Y5", 8'h00, 1'b0, 1'b0); tick();
    expect_out("R4 Y6 after Y5", 8'h80, 1'b0, 1'b0); tick();
    expect_out("R4 Y2 via x5=0", 8'h08, 1'b0, 1'b0); tick();
    expect_out("R10 done via x3=0", 8'h00, 1'b1, 1'b0);
  endtask

  // unwatched inputs change: no alarm
  task automatic t_unwatched();
    do_reset();
    launch(5'b00001);
    cond_i = 5'b00101; tick();       // x3 flips during Y1
    expect_out("R7 x3 flip in Y1", 8'h00, 1'b0, 1'b0);
    cond_i = 5'b00001; tick();
    expect_out("R7 continues to Y2", 8'h08, 1'b0, 1'b0);
    do_reset();
    launch(5'b00010);
    cond_i = 5'b00000; tick();       // x2 flips during Y4
    expect_out("R7 x2 flip in Y4", 8'h00, 1'b0, 1'b0); tick();
    expect_out("R7 Y2 after Y4", 8'h08, 1'b0, 1'b0); tick();
    expect_out("R7 run completes", 8'h00, 1'b1, 1'b0);
  endtask

  task automatic trip_tail(input string req);
    tick();
    expect_out(req, 8'h00, 1'b0, 1'b1);
  endtask

  task automatic t_check_fail();
    do_reset();
    launch(5'b00001);
    cond_i = 5'b00000; tick();       // x1 drops during Y1
    expect_out("R6 Y1 check cycle", 8'h00, 1'b0, 1'b0);
    trip_tail("R6 x1 lost after Y1");
    start = 1'b1; tick(); start = 1'b0;
    expect_out("R9 start ignored in halt", 8'h00, 1'b0, 1'b1);
    repeat (3) tick();
    expect_out("R9 alarm sticky", 8'h00, 1'b0, 1'b1);

    do_reset();
    launch(5'b11010); tick(); tick();
    expect_out("R6 in Y3", 8'h4C, 1'b0, 1'b0);
    cond_i = 5'b10010; tick();       // x4 drops during Y3
    trip_tail("R6 x4 lost after Y3");

    do_reset();
    launch(5'b00010);
    cond_i = 5'b00011; tick();       // x1 rises during Y4
    trip_tail("R6 x1 rose after Y4");

    do_reset();
    launch(5'b00000);
    cond_i = 5'b00010; tick();       // x2 rises during Y5
    trip_tail("R6 x2 rose after Y5");
  endtask

  task automatic t_illegal_state();
    do_reset();
    force dut.state_q = 13'b0000001000100;   // two bits set
    #1;
    expect_out("R8 outputs quiet on illegal state", 8'h00, 1'b0, 1'b0);
    tick();
    release dut.state_q;
    expect_out("R8 illegal state alarm", 8'h00, 1'b0, 1'b1);
    tick();
    expect_out("R9 halted after illegal state", 8'h00, 1'b0, 1'b1);
    do_reset();
    expect_out("R1 reset clears alarm", 8'h00, 1'b0, 1'b0);
  endtask

  task automatic finish_run();
    if (!over) begin
      over = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; cond_i = '0;
    t_path_a();
    t_path_b();
    t_path_c();
    t_unwatched();
    t_check_fail();
    t_illegal_state();
    finish_run();
  end
endmodule